// File: doc/BRIEF.md
# Clock-Pair Enable Register Target (Two-Wire Block Access)

This block is a target on a two-wire serial bus (I2C/SMBus standard mode). It holds six 8-bit control registers and turns the relevant bits into a 10-bit enable vector, one bit per differential clock output pair. A system clock much faster than the bus bit rate samples both bus lines. SDA is driven open-drain: while the SDA output enable is high, the line is pulled low.

There is no register addressing. A host writes with a block-write sequence. The block acknowledges the first two bytes after the address (a command code and a byte count) and throws them away. The data bytes that follow fill the registers in fixed order, starting at register 0. A host reads with a block-read sequence. The block returns a byte count of 6 and then the six registers in order. A stop may end either kind of transfer after any complete byte.

Top module: `clkpair_enable_regs`

## Requirements
- R1: The block acknowledges only the 7-bit address 0x69, that is 0xD2 for a write and 0xD3 for a read. Any other address gets no acknowledge, and the data that follows it changes no register.
- R2: In a write, the first two bytes after the address (command code, then byte count) are acknowledged and change no register.
- R3: Write data bytes go into registers 0, 1, 2, 3, 4, 5 in that order, and each one is acknowledged (SDA low in the ninth clock).
- R4: Write data bytes after the sixth are acknowledged and discarded.
- R5: A stop after any complete byte ends the write. Registers already written keep their new values, and the rest keep their old values.
- R6: Reset (rst_n low) loads 0xFF into registers 0 to 4 and 0x06 into register 5. After reset, all ten enable bits are 1 and SDA is released.
- R7: After a read address is acknowledged, the block sends the byte count 6 and then registers 0 to 5, each byte MSB first.
- R8: Enable bit p is bit 7-(p mod 8) of register p/8. So pairs 0 to 7 come from register 0, bit 7 down to bit 0, and pairs 8 and 9 come from register 1, bits 7 and 6. A value of 1 enables the pair. The enable vector changes only at the end of the acknowledge clock of a data byte, never while the byte is still arriving.
- R9: If a read goes on past register 5, or continues after the host has not acknowledged a byte, the block sends 0xFF (SDA released) until a stop.
- R10: A repeated start at any point restarts address matching. A write after it starts again at register 0.
- R11: The SDA output enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset, loads register defaults |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| clk_en_o | output | NUM_PAIRS | Enable for each differential clock pair, 1 = enabled |

## Verification
The bench fills the registers with partial block-writes of different lengths and reads all of them back after each one. A design that ignored the two header bytes, or started at the wrong register, would show up as shifted read-back data. Overrun writes, reads that run past register 5, and reads that continue after a NACK probe the edges of the byte index. Wrong behaviour there would show up as a missing acknowledge, a corrupted register, or data driven where 0xFF belongs. Further tests cover a repeated start in the middle of a transfer and a foreign address, and catch a design that did not rescan the address or that acknowledged the wrong device. One test captures the enable vector during the acknowledge clock, so a design that updated it before the byte was fully accepted would be caught.

// File: rtl/cpe_pkg.sv
package cpe_pkg;
    localparam int NUM_REGS  = 6;
    localparam int REG_W     = 8;
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam int BIT_W     = $clog2(REG_W);
    localparam int CNT_W     = 4;
    localparam int HDR_BYTES = 2;

    typedef logic [NUM_REGS-1:0][REG_W-1:0] regs_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } tgt_state_e;

    function automatic logic [REG_W-1:0] reg_default(input int idx);
        return (idx == NUM_REGS - 1) ? REG_W'(8'h06) : {REG_W{1'b1}};
    endfunction
endpackage

// File: rtl/cpe_line_sync.sv
module cpe_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_p;
        logic [SYNC_STAGES-1:0] sda_p;
        logic                   scl_prev;
        logic                   sda_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.scl_p    = {q.scl_p[SYNC_STAGES-2:0], scl_i};
        d.sda_p    = {q.sda_p[SYNC_STAGES-2:0], sda_i};
        d.scl_prev = q.scl_p[SYNC_STAGES-1];
        d.sda_prev = q.sda_p[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s     = q.scl_p[SYNC_STAGES-1];
    assign sda_s     = q.sda_p[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~q.scl_prev;
    assign scl_fall  = ~scl_s & q.scl_prev;
    // line events qualified by SCL high in both samples
    assign start_det = scl_s & q.scl_prev & q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & q.scl_prev & ~q.sda_prev & sda_s;
endmodule

// File: rtl/cpe_target_fsm.sv
module cpe_target_fsm
    import cpe_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  regs_t            regs_i,
    output logic             sda_oe_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [REG_W-1:0] wr_data_o
);
    localparam logic [CNT_W-1:0] HDR_CNT  = CNT_W'(HDR_BYTES);
    localparam logic [CNT_W-1:0] DATA_END = CNT_W'(HDR_BYTES + NUM_REGS);
    localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(NUM_REGS);
    localparam logic [REG_W-1:0] BYTE_CNT = REG_W'(NUM_REGS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(REG_W - 1);

    typedef struct packed {
        tgt_state_e       st;
        logic [BIT_W-1:0] bit_cnt;
        logic             full;
        logic [REG_W-1:0] sh;
        logic [CNT_W-1:0] byte_idx;
        logic             rw;
        logic             nack;
        logic             oe;
        logic             wr_en;
        logic [IDX_W-1:0] wr_idx;
        logic [REG_W-1:0] wr_data;
    } fsm_t;

    fsm_t q, d;
    logic [CNT_W-1:0] nxt_idx;
    logic [REG_W-1:0] tx_byte;

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        nxt_idx = (q.byte_idx == '1) ? q.byte_idx : q.byte_idx + 1'b1;
        tx_byte = '1;
        if (!q.nack) begin
            for (int k = 0; k < NUM_REGS; k++) begin
                if (nxt_idx == CNT_W'(k + 1)) tx_byte = regs_i[k];
            end
        end

        if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_det) begin
            d.st       = ST_ADDR;
            d.bit_cnt  = '0;
            d.full     = 1'b0;
            d.oe       = 1'b0;
            d.byte_idx = '0;
            d.nack     = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise) begin
                        d.sh      = {q.sh[REG_W-2:0], sda_s};
                        d.bit_cnt = q.bit_cnt + 1'b1;
                        if (q.bit_cnt == LAST_BIT) d.full = 1'b1;
                    end else if (scl_fall && q.full) begin
                        d.full = 1'b0;
                        if (q.st == ST_ADDR) begin
                            if (q.sh[REG_W-1:1] == DEV_ADDR) begin
                                d.st = ST_ADDR_ACK;
                                d.oe = 1'b1;
                                d.rw = q.sh[0];
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            d.st = ST_WR_ACK;
                            d.oe = 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.bit_cnt = '0;
                        if (q.rw) begin
                            d.st = ST_RD_BYTE;
                            d.sh = BYTE_CNT;
                            d.oe = ~BYTE_CNT[REG_W-1];
                        end else begin
                            d.st = ST_WR_BYTE;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        d.st       = ST_WR_BYTE;
                        d.oe       = 1'b0;
                        d.bit_cnt  = '0;
                        d.byte_idx = nxt_idx;
                        if (q.byte_idx >= HDR_CNT && q.byte_idx < DATA_END) begin
                            d.wr_en   = 1'b1;
                            d.wr_idx  = IDX_W'(q.byte_idx - HDR_CNT);
                            d.wr_data = q.sh;
                        end
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        d.bit_cnt = q.bit_cnt + 1'b1;
                        if (q.bit_cnt == LAST_BIT) begin
                            d.st = ST_RD_ACK;
                            d.oe = 1'b0;
                        end else begin
                            d.sh = {q.sh[REG_W-2:0], 1'b1};
                            d.oe = ~q.sh[REG_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        if (sda_s) d.nack = 1'b1;
                    end else if (scl_fall) begin
                        d.st       = ST_RD_BYTE;
                        d.bit_cnt  = '0;
                        d.byte_idx = nxt_idx;
                        d.sh       = (nxt_idx > RD_LAST) ? '1 : tx_byte;
                        d.oe       = (nxt_idx > RD_LAST) ? 1'b0 : ~tx_byte[REG_W-1];
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o  = q.oe;
    assign wr_en_o   = q.wr_en;
    assign wr_idx_o  = q.wr_idx;
    assign wr_data_o = q.wr_data;
endmodule

// File: rtl/cpe_reg_bank.sv
module cpe_reg_bank
    import cpe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_data,
    output regs_t            regs_o
);
    regs_t regs_q, regs_d;

    always_comb begin
        regs_d = regs_q;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (wr_en && wr_idx == IDX_W'(k)) regs_d[k] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_REGS; k++) regs_q[k] <= reg_default(k);
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;
endmodule

// File: rtl/clkpair_enable_regs.sv
module clkpair_enable_regs
    import cpe_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_PAIRS   = 10,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe_o,
    output logic [NUM_PAIRS-1:0] clk_en_o
);
    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [REG_W-1:0] wr_data;
    regs_t            regs;

    cpe_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    cpe_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .regs_i   (regs),
        .sda_oe_o (sda_oe_o),
        .wr_en_o  (wr_en),
        .wr_idx_o (wr_idx),
        .wr_data_o(wr_data)
    );

    cpe_reg_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .regs_o (regs)
    );

    // pair p: register p/8, bit 7-(p mod 8)
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        assign clk_en_o[p] = regs[p / REG_W][REG_W - 1 - (p % REG_W)];
    end
endmodule

// File: rtl/cpe_checker.sv
module cpe_checker
    import cpe_pkg::*;
#(
    parameter int NUM_PAIRS = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PAIRS-1:0] clk_en,
    input logic                 sda_oe,
    input logic                 scl_s,
    input logic                 start_det,
    input logic                 stop_det,
    input logic                 wr_en,
    input logic [IDX_W-1:0]     wr_idx
);
    assert_reset_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (clk_en == '1))
        else $error("enable vector not all ones after reset");

    assert_en_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_en) |-> $past(wr_en))
        else $error("enable vector moved without a committed byte");

    assert_sda_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s))
        else $error("SDA drive changed while SCL high");

    assert_wr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDX_W'(NUM_REGS)))
        else $error("write strobe beyond last register");
endmodule

bind clkpair_enable_regs cpe_checker #(.NUM_PAIRS(NUM_PAIRS)) u_cpe_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en_o),
    .sda_oe   (sda_oe_o),
    .scl_s    (scl_s),
    .start_det(start_det),
    .stop_det (stop_det),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx)
);

// File: tb/test_clkpair_enable_regs.sv
module test_clkpair_enable_regs;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       host_sda = 1'b1;
    wire        sda_oe;
    wire [9:0]  clk_en;
    wire        sda_line = host_sda & ~sda_oe;

    int         nchk = 0;
    int         nfail = 0;
    int         r11_viol = 0;
    logic       done = 1'b0;
    logic [7:0] model [6];
    logic       a;
    logic [7:0] d;
    logic [9:0] en_pre;
    logic [9:0] en_old;
    int         n;

    always #4 clk = ~clk;

    clkpair_enable_regs i_clkpair_enable_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .sda_oe_o(sda_oe),
        .clk_en_o(clk_en)
    );

    always @(sda_oe) if (rst_n && scl) r11_viol++;

    // {count, byte0..byte5}
    localparam logic [51:0] VECS [6] = '{
        {4'd6, 48'h00_11_22_33_44_55},
        {4'd2, 48'hA5_3C_00_00_00_00},
        {4'd1, 48'h0F_00_00_00_00_00},
        {4'd6, 48'hFF_FF_FF_FF_FF_06},
        {4'd3, 48'h81_40_7E_00_00_00},
        {4'd0, 48'h00_00_00_00_00_00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] exp_en();
        logic [9:0] e;
        for (int p = 0; p < 10; p++) e[p] = model[p / 8][7 - (p % 8)];
        return e;
    endfunction

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        host_sda = 1'b1; wq(); scl = 1'b1; wq();
        host_sda = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        host_sda = 1'b0; wq(); scl = 1'b1; wq();
        host_sda = 1'b1; wq(); wq();
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            host_sda = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        end
        host_sda = 1'b1; wq(); scl = 1'b1; wq();
        ack = sda_line; en_pre = clk_en;
        wq(); scl = 1'b0; wq();
    endtask

    task automatic rbyte(input logic nack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            host_sda = 1'b1; wq(); scl = 1'b1; wq();
            v[i] = sda_line;
            wq(); scl = 1'b0; wq();
        end
        host_sda = nack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        host_sda = 1'b1;
    endtask

    task automatic write_hdr(input string req);
        i2c_start();
        wbyte(8'hD2, a); chk({req, " write address ack"}, a, 1'b0);
        wbyte(8'hC3, a); chk("R2 command byte ack", a, 1'b0);
        wbyte(8'h99, a); chk("R2 count byte ack", a, 1'b0);
    endtask

    task automatic read_back(input string req);
        i2c_start();
        wbyte(8'hD3, a); chk("R7 read address ack", a, 1'b0);
        rbyte(1'b0, d);  chk("R7 byte count", d, 8'd6);
        for (int k = 0; k < 6; k++) begin
            rbyte(k == 5, d);
            chk(req, d, model[k]);
        end
        i2c_stop();
    endtask

    initial begin
        repeat (Q * 24000) @(negedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 5; k++) model[k] = 8'hFF;
        model[5] = 8'h06;
        repeat (5) @(negedge clk);
        chk("R6 enables in reset", clk_en, 10'h3FF);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 enables after reset", clk_en, 10'h3FF);
        chk("R6 SDA released", sda_oe, 1'b0);
        read_back("R6 default readback");

        // R3 R5 R7 R8: vector table of partial block writes
        for (int v = 0; v < 6; v++) begin
            n = int'(VECS[v][51:48]);
            write_hdr("R3");
            for (int k = 0; k < n; k++) begin
                wbyte(VECS[v][47 - 8 * k -: 8], a);
                chk("R3 data byte ack", a, 1'b0);
                model[k] = VECS[v][47 - 8 * k -: 8];
            end
            i2c_stop();
            chk("R8 enable vector map", clk_en, exp_en());
            read_back("R5 readback after partial write");
        end

        // R8: enable must not move until the byte's ack clock ends
        write_hdr("R8");
        en_old = clk_en;
        wbyte(8'h3C, a);
        model[0] = 8'h3C;
        chk("R8 enable held during ack", en_pre, en_old);
        chk("R8 enable updated after ack", clk_en, exp_en());
        i2c_stop();

        // R4: overrun write
        write_hdr("R4");
        for (int k = 0; k < 8; k++) begin
            wbyte(8'hA0 + 8'(k), a);
            chk("R4 overrun byte ack", a, 1'b0);
            if (k < 6) model[k] = 8'hA0 + 8'(k);
        end
        i2c_stop();
        read_back("R4 overrun discarded");

        // R1: foreign addresses
        i2c_start();
        wbyte(8'hA4, a); chk("R1 foreign address nack", a, 1'b1);
        wbyte(8'h00, a); wbyte(8'h00, a); wbyte(8'h5A, a);
        i2c_stop();
        i2c_start();
        wbyte(8'hD0, a); chk("R1 neighbour address nack", a, 1'b1);
        wbyte(8'h00, a); wbyte(8'h00, a); wbyte(8'h5A, a);
        i2c_stop();
        read_back("R1 registers untouched");

        // R10: repeated start restarts matching and write index
        write_hdr("R10");
        wbyte(8'h12, a);
        write_hdr("R10");
        wbyte(8'h34, a); chk("R10 data after restart ack", a, 1'b0);
        i2c_stop();
        model[0] = 8'h34;
        i2c_start();
        wbyte(8'hD2, a); wbyte(8'h00, a);
        i2c_start();
        wbyte(8'hD3, a); chk("R10 read after restart ack", a, 1'b0);
        rbyte(1'b0, d);  chk("R10 count after restart", d, 8'd6);
        rbyte(1'b1, d);  chk("R10 byte0 after restart", d, model[0]);
        i2c_stop();
        read_back("R10 register 1 kept");

        // R9: read past the last register
        i2c_start();
        wbyte(8'hD3, a);
        rbyte(1'b0, d);
        for (int k = 0; k < 6; k++) begin
            rbyte(1'b0, d); chk("R7 full read data", d, model[k]);
        end
        rbyte(1'b0, d); chk("R9 read past end", d, 8'hFF);
        rbyte(1'b1, d); chk("R9 read past end second", d, 8'hFF);
        i2c_stop();

        // R9: continue after NACK
        i2c_start();
        wbyte(8'hD3, a);
        rbyte(1'b1, d); chk("R9 count before nack", d, 8'd6);
        rbyte(1'b1, d); chk("R9 byte after nack", d, 8'hFF);
        i2c_stop();

        chk("R11 SDA changes with SCL high", r11_viol, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule